// File: doc/BRIEF.md
# Framed Serial Receive Buffer with Status Word

This block is the receive side of a bit-serial channel controller. It takes one line bit per qualified clock and runs in one of two modes. In framed mode it hunts for the 01111110 delimiter and deletes the zero inserted after every five consecutive ones. It treats seven or more ones as an abort. It packs the recovered bits, least significant first, into bytes and runs a reflected CRC-16 (polynomial 0x8408, preset all-ones) over them. In transparent mode it packs every line bit into bytes and does no framing at all.

Bytes collect in a buffer of `FIFO_BYTES` entries. A block is handed to the host when the buffer fills or, in framed mode, when a frame ends. Handing over a block raises the ready flag and freezes the block. The host then reads one 32-bit status word and pops the block as little-endian 32-bit words. Popping the last word that covers the block frees the buffer. A byte or frame end that arrives while a block is still frozen is dropped and flagged as overflow. A single receiver-reset strobe puts everything back to its reset state.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: After reset the status word reads `VERSION` in bits 27:24 and zero everywhere else, and `rxReady` is low.
- R2: In framed mode, bits between two delimiters are de-stuffed and stored in arrival order as bytes (first bit received is bit 0). Delimiters with no data between them produce no block.
- R3: A closing delimiter after data freezes the block with status bit 0 (end of frame) set and bits 8 and up holding the byte count of that block (FCS bytes included), and it raises bit 5 (ready).
- R4: At a frame end, bit 1 is set when the CRC residue equals 0xF0B8. Bit 2 is set when the frame is a whole number of bytes and at least 4 bytes long. Bit 3 is set, with bits 1 and 2 clear, when the frame ended by abort (seven ones). A frame is good only when bits 3:1 equal 3'b011.
- R5: When `FIFO_BYTES` bytes gather without a frame end, the block is frozen with a length field of 0, bit 0 clear and bit 5 set.
- R6: `dataWord` shows the next four block bytes little-endian (lowest address in bits 7:0). Each `dataRd` advances by four bytes. The pop that covers the block frees it, and the length field and bits 3:0 return to 0.
- R7: A `statRd` strobe clears bits 5 and 4 unless a new event sets them in the same cycle.
- R8: A byte or frame end that arrives while a block is frozen is dropped and sets bits 4 (overflow) and 5. The frozen block is left unchanged.
- R9: A `rxResetCmd` strobe empties the buffer, clears all status bits and sends framed mode back to delimiter hunting.
- R10: In transparent mode, delimiter, stuffing and abort patterns are stored as ordinary data. Blocks are frozen only when the buffer is full, with bits 3:0 zero.
- R11: `rxReady` always equals status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lineBit | input | 1 | Received line bit |
| lineValid | input | 1 | Qualifies `lineBit` for one cycle |
| transparentMode | input | 1 | 1: raw byte packing, 0: framed mode |
| statRd | input | 1 | Host status read strobe (clears ready and overflow) |
| statusWord | output | 32 | Status word |
| dataRd | input | 1 | Host data read strobe (pops four bytes) |
| dataWord | output | 32 | Next four block bytes, little-endian |
| rxResetCmd | input | 1 | Receiver reset strobe |
| rxReady | output | 1 | Receive-ready interrupt |

## Verification
The hardest state to reach is a block boundary in the middle of a frame. The delimiter stripper holds seven bits back, so the byte that fills the buffer is stored only several line bits after it was sent. The bench stops the line after the 33rd byte of a 40-byte frame, services the full block and then resumes the same frame. This checks that the CRC and the length count carry across the boundary. The same frame is then sent again with no service at all, which forces the late bytes and the frame end into overflow.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  // Strobes from control to the byte store
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } storeCmd_t;

  // Quality flags reported with a frame end
  typedef struct packed {
    logic crcOk;
    logic sized;
    logic aborted;
  } endInfo_t;

  localparam logic [15:0] CRC_POLY_REFL    = 16'h8408;
  localparam logic [15:0] CRC_GOOD_RESIDUE = 16'hF0B8;
  localparam int          MIN_FRAME_BYTES  = 4;
endpackage

// File: rtl/hdlc_rx_linedec.sv
module hdlc_rx_linedec
  import hdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lineBit,
  input  logic       lineValid,
  input  logic       transparentMode,
  input  logic       flush,
  output logic       byteValid,
  output logic [7:0] byteData,
  output logic       endValid,
  output endInfo_t   endInfo
);
  localparam int DLY_LEN = 7;

  logic [2:0]         onesRun;
  logic [DLY_LEN-1:0] dlyBits;
  logic [2:0]         dlyCnt;
  logic               inFrame;
  logic [7:0]         shReg;
  logic [2:0]         bitCnt;
  logic [15:0]        crcReg;
  logic [2:0]         frameBytes;

  logic pushBit, pushVal, flagSeen, abortSeen;
  logic dataValid, dataVal, fbBit, hasData;
  logic [15:0] crcNext;

  always_comb begin
    pushBit   = 1'b0;
    pushVal   = 1'b0;
    flagSeen  = 1'b0;
    abortSeen = 1'b0;
    if (lineValid && !transparentMode) begin
      if (lineBit) begin
        if (onesRun == 3'd6)      abortSeen = 1'b1;
        else if (onesRun != 3'd7) begin pushBit = 1'b1; pushVal = 1'b1; end
      end else begin
        if (onesRun == 3'd6)      flagSeen = 1'b1;
        else if (onesRun != 3'd5) begin pushBit = 1'b1; pushVal = 1'b0; end
      end
    end
    // Delimiter bits sit in the delay line and are discarded when recognised
    dataValid = transparentMode ? lineValid
                                : (pushBit && (dlyCnt == 3'(DLY_LEN)) && inFrame);
    dataVal   = transparentMode ? lineBit : dlyBits[DLY_LEN-1];
    fbBit     = crcReg[0] ^ dataVal;
    crcNext   = {1'b0, crcReg[15:1]} ^ (fbBit ? CRC_POLY_REFL : 16'h0000);
    hasData   = (frameBytes != 3'd0) || (bitCnt != 3'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onesRun <= '0; dlyBits <= '0; dlyCnt <= '0; inFrame <= 1'b0;
      shReg <= '0; bitCnt <= '0; crcReg <= 16'hFFFF; frameBytes <= '0;
      byteValid <= 1'b0; byteData <= '0; endValid <= 1'b0; endInfo <= '0;
    end else if (flush) begin
      onesRun <= '0; dlyBits <= '0; dlyCnt <= '0; inFrame <= 1'b0;
      shReg <= '0; bitCnt <= '0; crcReg <= 16'hFFFF; frameBytes <= '0;
      byteValid <= 1'b0; endValid <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      endValid  <= 1'b0;
      if (lineValid && !transparentMode) begin
        if (lineBit) onesRun <= (onesRun >= 3'd6) ? 3'd7 : onesRun + 3'd1;
        else         onesRun <= 3'd0;
      end
      if (pushBit) begin
        dlyBits <= {dlyBits[DLY_LEN-2:0], pushVal};
        if (dlyCnt != 3'(DLY_LEN)) dlyCnt <= dlyCnt + 3'd1;
      end
      if (dataValid) begin
        shReg  <= {dataVal, shReg[7:1]};
        bitCnt <= bitCnt + 3'd1;
        crcReg <= crcNext;
        if (bitCnt == 3'd7) begin
          byteValid <= 1'b1;
          byteData  <= {dataVal, shReg[7:1]};
          if (frameBytes < 3'(MIN_FRAME_BYTES)) frameBytes <= frameBytes + 3'd1;
        end
      end
      if (flagSeen) begin
        if (inFrame && hasData) begin
          endValid        <= 1'b1;
          endInfo.crcOk   <= (crcReg == CRC_GOOD_RESIDUE);
          endInfo.sized   <= (bitCnt == 3'd0) && (frameBytes >= 3'(MIN_FRAME_BYTES));
          endInfo.aborted <= 1'b0;
        end
        inFrame <= 1'b1; dlyCnt <= '0; bitCnt <= '0;
        crcReg <= 16'hFFFF; frameBytes <= '0;
      end
      if (abortSeen) begin
        if (inFrame && hasData) begin
          endValid        <= 1'b1;
          endInfo.crcOk   <= 1'b0;
          endInfo.sized   <= 1'b0;
          endInfo.aborted <= 1'b1;
        end
        inFrame <= 1'b0; dlyCnt <= '0; bitCnt <= '0;
        crcReg <= 16'hFFFF; frameBytes <= '0;
      end
    end
  end

  // R2: a completed byte and a frame end never come out together
  assert_byte_end_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(byteValid && endValid));

  // R10: transparent mode never reports a frame end
  assert_transparent_no_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(transparentMode) && !$past(flush) |-> !endValid);
endmodule

// File: rtl/hdlc_rx_store.sv
module hdlc_rx_store
  import hdlc_rx_pkg::*;
#(
  parameter int FIFO_BYTES = 32,
  localparam int CNT_W = $clog2(FIFO_BYTES + 1),
  localparam int PTR_W = CNT_W + 1,
  localparam int IDX_W = $clog2(FIFO_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  storeCmd_t        cmd,
  input  logic [7:0]       byteIn,
  output logic [CNT_W-1:0] wrCount,
  output logic [PTR_W-1:0] rdPtr,
  output logic [31:0]      dataWord
);
  logic [7:0] mem [FIFO_BYTES];

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrCount[IDX_W-1:0]] <= byteIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrCount <= '0;
      rdPtr   <= '0;
    end else if (cmd.clear) begin
      wrCount <= '0;
      rdPtr   <= '0;
    end else begin
      if (cmd.push) wrCount <= wrCount + CNT_W'(1);
      if (cmd.pop)  rdPtr   <= rdPtr + PTR_W'(4);
    end
  end

  for (genvar g = 0; g < 4; g++) begin : gLane
    logic [IDX_W-1:0] laneIdx;
    assign laneIdx = rdPtr[IDX_W-1:0] + IDX_W'(g);
    assign dataWord[8*g +: 8] = mem[laneIdx];
  end

  // R5: the store never holds more than its capacity
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrCount <= CNT_W'(FIFO_BYTES));
endmodule

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int          FIFO_BYTES = 32,
  parameter logic [3:0]  VERSION    = 4'h2,
  localparam int CNT_W = $clog2(FIFO_BYTES + 1),
  localparam int PTR_W = CNT_W + 1,
  localparam int LEN_W = (FIFO_BYTES <= 32) ? 6 : 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byteValid,
  input  logic             endValid,
  input  endInfo_t         endInfo,
  input  logic             statRd,
  input  logic             dataRd,
  input  logic             rxResetCmd,
  input  logic [CNT_W-1:0] wrCount,
  input  logic [PTR_W-1:0] rdPtr,
  output storeCmd_t        cmd,
  output logic [31:0]      statusWord,
  output logic             rxReady
);
  logic             held;
  logic [CNT_W-1:0] heldLen;
  logic             rmeBit, crcBit, sizedBit, abortBit, rprBit, rdoBit;
  logic             fullNow, releaseNow, overflowEv, blockEv;
  logic [LEN_W-1:0] lenField;

  always_comb begin
    fullNow    = byteValid && !held && (wrCount == CNT_W'(FIFO_BYTES - 1));
    releaseNow = dataRd && held && ((rdPtr + PTR_W'(4)) >= PTR_W'(heldLen));
    overflowEv = held && (byteValid || endValid);
    blockEv    = fullNow || (endValid && !held);
    cmd.push   = byteValid && !held && !rxResetCmd;
    cmd.pop    = dataRd && held && !rxResetCmd;
    cmd.clear  = rxResetCmd || releaseNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0; heldLen <= '0; rmeBit <= 1'b0; crcBit <= 1'b0;
      sizedBit <= 1'b0; abortBit <= 1'b0; rprBit <= 1'b0; rdoBit <= 1'b0;
    end else if (rxResetCmd) begin
      held <= 1'b0; heldLen <= '0; rmeBit <= 1'b0; crcBit <= 1'b0;
      sizedBit <= 1'b0; abortBit <= 1'b0; rprBit <= 1'b0; rdoBit <= 1'b0;
    end else begin
      if (releaseNow) begin
        held <= 1'b0; heldLen <= '0; rmeBit <= 1'b0;
        crcBit <= 1'b0; sizedBit <= 1'b0; abortBit <= 1'b0;
      end
      if (fullNow) begin
        held <= 1'b1; heldLen <= CNT_W'(FIFO_BYTES); rmeBit <= 1'b0;
        crcBit <= 1'b0; sizedBit <= 1'b0; abortBit <= 1'b0;
      end
      if (endValid && !held) begin
        held     <= 1'b1;
        heldLen  <= wrCount;
        rmeBit   <= 1'b1;
        crcBit   <= endInfo.crcOk;
        sizedBit <= endInfo.sized;
        abortBit <= endInfo.aborted;
      end
      if (blockEv || overflowEv) rprBit <= 1'b1;
      else if (statRd)           rprBit <= 1'b0;
      if (overflowEv)            rdoBit <= 1'b1;
      else if (statRd)           rdoBit <= 1'b0;
    end
  end

  always_comb begin
    lenField = (heldLen == CNT_W'(FIFO_BYTES)) ? '0 : LEN_W'(heldLen);
    statusWord               = 32'd0;
    statusWord[27:24]        = VERSION;
    statusWord[8 +: LEN_W]   = lenField;
    statusWord[5]            = rprBit;
    statusWord[4]            = rdoBit;
    statusWord[3]            = abortBit;
    statusWord[2]            = sizedBit;
    statusWord[1]            = crcBit;
    statusWord[0]            = rmeBit;
    rxReady                  = rprBit;
  end

  // R3: freezing a block always raises the ready flag
  assert_block_raises_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> rprBit);

  // R8: while a block is frozen the store does not take bytes
  assert_frozen_store_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    held && !cmd.clear |=> wrCount == $past(wrCount));

  // R7: a status read with no competing event clears ready and overflow
  assert_status_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    statRd && !byteValid && !endValid && !rxResetCmd |=> !rprBit && !rdoBit);

  // R9: the receiver reset command empties everything
  assert_reset_cmd_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rxResetCmd |=> !held && !rprBit && !rdoBit && (wrCount == '0));
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import hdlc_rx_pkg::*;
#(
  parameter int         FIFO_BYTES = 32,
  parameter logic [3:0] VERSION    = 4'h2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lineBit,
  input  logic        lineValid,
  input  logic        transparentMode,
  input  logic        statRd,
  output logic [31:0] statusWord,
  input  logic        dataRd,
  output logic [31:0] dataWord,
  input  logic        rxResetCmd,
  output logic        rxReady
);
  localparam int CNT_W = $clog2(FIFO_BYTES + 1);
  localparam int PTR_W = CNT_W + 1;

  logic             byteValid, endValid;
  logic [7:0]       byteData;
  endInfo_t         endInfo;
  storeCmd_t        cmd;
  logic [CNT_W-1:0] wrCount;
  logic [PTR_W-1:0] rdPtr;

  hdlc_rx_linedec uLineDec (
    .clk(clk), .rst_n(rst_n), .lineBit(lineBit), .lineValid(lineValid),
    .transparentMode(transparentMode), .flush(rxResetCmd),
    .byteValid(byteValid), .byteData(byteData),
    .endValid(endValid), .endInfo(endInfo)
  );

  hdlc_rx_ctrl #(.FIFO_BYTES(FIFO_BYTES), .VERSION(VERSION)) uCtrl (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .endValid(endValid),
    .endInfo(endInfo), .statRd(statRd), .dataRd(dataRd),
    .rxResetCmd(rxResetCmd), .wrCount(wrCount), .rdPtr(rdPtr),
    .cmd(cmd), .statusWord(statusWord), .rxReady(rxReady)
  );

  hdlc_rx_store #(.FIFO_BYTES(FIFO_BYTES)) uStore (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .byteIn(byteData),
    .wrCount(wrCount), .rdPtr(rdPtr), .dataWord(dataWord)
  );
endmodule

// File: tb/tb_hdlc_rx_fifo.sv
module tb_hdlc_rx_fifo;
  localparam int         FB  = 32;
  localparam logic [3:0] VER = 4'h2;
  localparam logic [31:0] LEN_MASK = 32'h0000_3F00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lineBit = 1'b0, lineValid = 1'b0, transparentMode = 1'b0;
  logic statRd = 1'b0, dataRd = 1'b0, rxResetCmd = 1'b0;
  logic [31:0] statusWord, dataWord;
  logic rxReady;

  int checks = 0;
  int fails = 0;
  int onesRun = 0;
  logic [7:0] fbuf [0:63];

  always #2 clk = ~clk;

  hdlc_rx_fifo #(.FIFO_BYTES(FB), .VERSION(VER)) dut (
    .clk(clk), .rst_n(rst_n), .lineBit(lineBit), .lineValid(lineValid),
    .transparentMode(transparentMode), .statRd(statRd), .statusWord(statusWord),
    .dataRd(dataRd), .dataWord(dataWord), .rxResetCmd(rxResetCmd), .rxReady(rxReady)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus(input int len, input bit rme, input bit crc,
      input bit sized, input bit abrt, input bit rdo, input bit rpr);
    logic [31:0] s;
    s = {4'h0, VER, 24'h0};
    s[13:8] = (len == FB) ? 6'd0 : 6'(len);
    s[5] = rpr; s[4] = rdo; s[3] = abrt; s[2] = sized; s[1] = crc; s[0] = rme;
    return s;
  endfunction

  function automatic logic [15:0] crcOver(input int first, input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = first; i < first + n; i++)
      for (int b = 0; b < 8; b++) begin
        logic f;
        f = c[0] ^ fbuf[i][b];
        c = {1'b0, c[15:1]} ^ (f ? 16'h8408 : 16'h0000);
      end
    return c;
  endfunction

  task automatic appendFcs(input int n);
    logic [15:0] f;
    f = ~crcOver(0, n);
    fbuf[n]   = f[7:0];
    fbuf[n+1] = f[15:8];
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rawBit(input logic b);
    @(negedge clk);
    lineBit = b; lineValid = 1'b1;
    @(negedge clk);
    lineValid = 1'b0;
  endtask

  task automatic dataByte(input logic [7:0] v);
    for (int b = 0; b < 8; b++) begin
      rawBit(v[b]);
      if (v[b]) begin
        onesRun++;
        if (onesRun == 5) begin rawBit(1'b0); onesRun = 0; end
      end else onesRun = 0;
    end
  endtask

  task automatic rawByte(input logic [7:0] v);
    for (int b = 0; b < 8; b++) rawBit(v[b]);
  endtask

  task automatic sendFlag();
    rawByte(8'h7E);
    onesRun = 0;
  endtask

  task automatic sendAbort();
    rawByte(8'hFF);
    onesRun = 0;
  endtask

  task automatic sendBytes(input int first, input int last);
    for (int i = first; i <= last; i++) dataByte(fbuf[i]);
  endtask

  task automatic readStatus(output logic [31:0] s);
    @(negedge clk);
    s = statusWord;
    statRd = 1'b1;
    @(negedge clk);
    statRd = 1'b0;
  endtask

  task automatic readWord(output logic [31:0] w);
    @(negedge clk);
    w = dataWord;
    dataRd = 1'b1;
    @(negedge clk);
    dataRd = 1'b0;
  endtask

  task automatic pulseReset();
    @(negedge clk);
    rxResetCmd = 1'b1;
    @(negedge clk);
    rxResetCmd = 1'b0;
  endtask

  task automatic checkWords(input int base, input int count, input string tag);
    for (int w = 0; w < (count + 3) / 4; w++) begin
      logic [31:0] got, exp, mask;
      readWord(got);
      exp = '0; mask = '0;
      for (int b = 0; b < 4; b++)
        if (4*w + b < count) begin
          exp[8*b +: 8]  = fbuf[base + 4*w + b];
          mask[8*b +: 8] = 8'hFF;
        end
      chk(tag, got & mask, exp);
    end
  endtask

  task automatic testReset();
    chk("R1 reset status", statusWord, {4'h0, VER, 24'h0});
    chk("R1 R11 reset rxReady", 32'(rxReady), 32'd0);
  endtask

  task automatic testIdleFlags();
    sendFlag(); sendFlag(); sendFlag();
    idle(4);
    chk("R2 idle delimiters give no block", statusWord, {4'h0, VER, 24'h0});
  endtask

  task automatic testGoodFrame();
    logic [31:0] s;
    fbuf[0] = 8'h7E; fbuf[1] = 8'hFF; fbuf[2] = 8'h3C;
    fbuf[3] = 8'h00; fbuf[4] = 8'hF8; fbuf[5] = 8'h1F;
    appendFcs(6);
    sendFlag(); sendBytes(0, 7); sendFlag();
    idle(4);
    chk("R11 rxReady at frame end", 32'(rxReady), 32'd1);
    readStatus(s);
    chk("R3 R4 good frame status", s, expStatus(8, 1, 1, 1, 0, 0, 1));
    chk("R7 rxReady after status read", 32'(rxReady), 32'd0);
    readStatus(s);
    chk("R7 ready bit cleared", s, expStatus(8, 1, 1, 1, 0, 0, 0));
    checkWords(0, 8, "R2 R6 destuffed words");
    readStatus(s);
    chk("R6 block released", s, {4'h0, VER, 24'h0});
  endtask

  task automatic testBadCrc();
    logic [31:0] s;
    for (int i = 0; i < 5; i++) fbuf[i] = 8'(8'h21 + 8'(i * 13));
    appendFcs(5);
    fbuf[5] = fbuf[5] ^ 8'h01;
    sendFlag(); sendBytes(0, 6); sendFlag();
    idle(4);
    readStatus(s);
    chk("R4 bad crc status", s,
        expStatus(7, 1, crcOver(0, 7) == 16'hF0B8, 1, 0, 0, 1));
    checkWords(0, 7, "R6 bad crc words");
    readStatus(s);
    chk("R6 release after bad frame", s, {4'h0, VER, 24'h0});
  endtask

  task automatic testShortFrame();
    logic [31:0] s;
    fbuf[0] = 8'hA5; fbuf[1] = 8'h5A; fbuf[2] = 8'hC3;
    sendFlag(); sendBytes(0, 2); sendFlag();
    idle(4);
    readStatus(s);
    chk("R4 short frame not sized", s,
        expStatus(3, 1, crcOver(0, 3) == 16'hF0B8, 0, 0, 0, 1));
    checkWords(0, 3, "R6 short frame words");
  endtask

  task automatic testAbort();
    logic [31:0] s;
    for (int i = 0; i < 5; i++) fbuf[i] = 8'(8'h10 + 8'(i));
    sendFlag(); sendBytes(0, 4); sendAbort();
    idle(4);
    readStatus(s);
    chk("R4 abort status", s & ~LEN_MASK, expStatus(0, 1, 0, 0, 1, 0, 1));
    pulseReset();
    readStatus(s);
    chk("R9 reset command clears", s, {4'h0, VER, 24'h0});
  endtask

  task automatic testFullFifo();
    logic [31:0] s;
    for (int i = 0; i < 40; i++) fbuf[i] = 8'(i * 37 + 5);
    appendFcs(40);
    sendFlag(); sendBytes(0, 32);
    idle(4);
    readStatus(s);
    chk("R5 full block status", s, expStatus(FB, 0, 0, 0, 0, 0, 1));
    checkWords(0, 32, "R5 R6 full block words");
    sendBytes(33, 41); sendFlag();
    idle(4);
    readStatus(s);
    chk("R3 R4 tail block status", s, expStatus(10, 1, 1, 1, 0, 0, 1));
    checkWords(32, 10, "R6 tail block words");
  endtask

  task automatic testOverflow();
    logic [31:0] s;
    pulseReset();
    sendFlag(); sendBytes(0, 41); sendFlag();
    idle(4);
    readStatus(s);
    chk("R8 overflow flagged", s, expStatus(FB, 0, 0, 0, 0, 1, 1));
    chk("R7 rxReady cleared", 32'(rxReady), 32'd0);
    readStatus(s);
    chk("R7 overflow cleared by read", s, expStatus(FB, 0, 0, 0, 0, 0, 0));
    checkWords(0, 4, "R8 frozen block kept");
    pulseReset();
    readStatus(s);
    chk("R9 reset after overflow", s, {4'h0, VER, 24'h0});
  endtask

  task automatic testTransparent();
    logic [31:0] s;
    transparentMode = 1'b1;
    pulseReset();
    for (int i = 0; i < FB; i++)
      fbuf[i] = (i % 3 == 0) ? 8'h7E : ((i % 3 == 1) ? 8'hFF : 8'(i * 9));
    for (int i = 0; i < FB; i++) rawByte(fbuf[i]);
    idle(4);
    readStatus(s);
    chk("R10 transparent block status", s, expStatus(FB, 0, 0, 0, 0, 0, 1));
    checkWords(0, FB, "R10 transparent raw words");
    readStatus(s);
    chk("R10 transparent release", s, {4'h0, VER, 24'h0});
    transparentMode = 1'b0;
    pulseReset();
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(2);
    testReset();
    testIdleFlags();
    testGoodFrame();
    testBadCrc();
    testShortFrame();
    testAbort();
    testFullFifo();
    testOverflow();
    testTransparent();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule